// File: doc/BRIEF.md
# Two-Wire Register-Space Slave

This block is the bus-facing half of a small timekeeping peripheral. It listens on a two-wire serial bus (clock and data, both open-drain) as a slave. It gives the bus master byte-wide access to a register space of 64 locations. The low eight locations are meant for clock and control registers and the rest for general-purpose RAM. The storage itself lives outside the block. The block drives a word pointer as the location address, issues a one-cycle write strobe with the received byte, and takes read data back combinationally from the storage at the pointer.

Both bus lines are oversampled in the system clock domain. Each line passes through a synchronizer and a glitch filter, and then an edge detector produces START, STOP and clock-edge events. The slave answers to one 7-bit device address. The master can load the word pointer and then stream bytes into consecutive locations. It can also read from a freshly loaded pointer using a repeated START, or read from wherever the pointer was left. The pointer advances only on an acknowledge clock and wraps at the top of the space. A power-fail input takes priority over everything else. It aborts any transfer, clears the pointer and makes the block deaf to the bus for as long as it is held.

Top module: `twi_regfile_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits are 1101000: value D0h selects a write and D1h selects a read. Any other address byte gets no acknowledge, and the slave stays silent and writes nothing until the next START.
- R2: In a write transfer, the first byte after the address loads the word pointer (reg_addr). Each later byte is strobed out on reg_wdata with a single-cycle reg_wr_en at the current pointer, and the pointer then steps up by one.
- R3: An acknowledge is the slave holding SDA low (sda_oe = 1) through the ninth clock. It is given for the address byte, the word-pointer byte and every data byte the slave receives.
- R4: A read sends the byte at the current pointer, MSB first. The pointer steps up by one only when the master acknowledges that byte, and otherwise keeps its value.
- R5: After the master leaves a read byte unacknowledged, the slave keeps SDA released (sda_oe = 0) so that the master can issue STOP.
- R6: A read that is not preceded by a pointer load starts at the pointer value left by the previous transfer.
- R7: While pwr_fail is high, any transfer is dropped, the pointer becomes 0, sda_oe and reg_wr_en stay low, and all bus activity, START included, is ignored.
- R8: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a STOP, clocked bytes are ignored until a new START.
- R9: A pulse on either line that lasts fewer than FILT_LEN synchronized samples has no effect on the transfer.
- R10: The pointer wraps from 63 to 0, both when writing and when reading.
- R11: A repeated START with no STOP before it is accepted and restarts the address phase. Bytes written before it stay written.
- R12: sda_oe changes only while SCL is low, and only after the low level has been seen by the filtered sampler.
- R13: After reset, sda_oe and reg_wr_en are 0 and reg_addr is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples both bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_fail | input | 1 | Supply out of tolerance: abort, clear pointer, ignore bus |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |
| reg_addr | output | ADDR_W | Word pointer, used as the storage location address |
| reg_wr_en | output | 1 | One-cycle write strobe into the storage |
| reg_wdata | output | 8 | Byte to be written at reg_addr |
| reg_rdata | input | 8 | Storage contents at reg_addr |

## Verification
The hardest case to reach from the pins is a power failure in the middle of a byte. The pointer must be cleared there, the half-received byte must never reach the storage, and the START and address bytes that arrive while power-fail is held must draw no acknowledge. The bench builds this case by hand: it writes one byte, shifts in three bits of a second byte, raises pwr_fail, and keeps clocking a full START plus address sequence before it releases the input. Glitches are forced through an XOR on each pad. The bench pulses SCL briefly in the middle of the low phase and SDA briefly during the high phase, and it does this during both a write and a read, so that a filter that is too short would count extra bits or detect a false STOP. A seeded random mix of writes, pointer-load reads and current-pointer reads is biased toward the top of the space, so that wrapping happens often under both access directions.

// File: rtl/twi_rf_pkg.sv
package twi_rf_pkg;

   localparam int BYTE_W    = 8;
   localparam int BIT_IDX_W = $clog2(BYTE_W);
   localparam int LINE_CNT  = 2;   // index 0: clock line, index 1: data line

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK_OUT,
      ST_TX_LOAD,
      ST_TX,
      ST_ACK_IN
   } core_state_t;

   typedef enum logic [1:0] {
      RX_DEVADDR,
      RX_PTR,
      RX_DATA
   } rx_kind_t;

endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   localparam int CNT_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

   initial begin
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
      assert (FILT_LEN >= 0 && FILT_LEN <= 1024) else $error("FILT_LEN out of range");
   end

   logic sync_bit;

   // synchronizer: a single stage or a chain, chosen by parameter
   if (SYNC_STAGES == 1) begin : g_sync_one
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= 1'b1;
         else        sync_q <= line_i;
      end
      assign sync_bit = sync_q;
   end else begin : g_sync_chain
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      end
      assign sync_bit = sync_q[SYNC_STAGES-1];
   end

   // glitch filter: a counted run of disagreeing samples, or a bypass
   if (FILT_LEN == 0) begin : g_no_filter
      assign line_o = sync_bit;
   end else begin : g_run_filter
      logic             level_q;
      logic [CNT_W-1:0] run_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            level_q <= 1'b1;
            run_q   <= '0;
         end else if (sync_bit == level_q) begin
            run_q <= '0;
         end else if (run_q == CNT_W'(FILT_LEN - 1)) begin
            level_q <= sync_bit;
            run_q   <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end

      assign line_o = level_q;

      AST_FILT_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
         (line_o != $past(line_o)) |-> ($past(sync_bit) == line_o)); // R9
   end

endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic ev_start,
   output logic ev_stop,
   output logic ev_rise,
   output logic ev_fall
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   // data moving while the clock stays high marks a bus condition
   assign ev_start = scl_f & scl_q & sda_q & ~sda_f;
   assign ev_stop  = scl_f & scl_q & ~sda_q & sda_f;
   assign ev_rise  = scl_f & ~scl_q;
   assign ev_fall  = ~scl_f & scl_q;

endmodule

// File: rtl/twi_slave_core.sv
module twi_slave_core
   import twi_rf_pkg::*;
#(
   parameter int         ADDR_W   = 6,
   parameter logic [6:0] DEV_ADDR = 7'h68
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_fail,
   input  logic              ev_start,
   input  logic              ev_stop,
   input  logic              ev_rise,
   input  logic              ev_fall,
   input  logic              scl_f,
   input  logic              sda_f,
   input  logic [BYTE_W-1:0] reg_rdata,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_wr_en,
   output logic [BYTE_W-1:0] reg_wdata
);

   localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= BYTE_W) else $error("ADDR_W must fit in one byte");
   end

   core_state_t          state_q;
   rx_kind_t             kind_q;
   logic [BIT_IDX_W-1:0] bit_q;
   logic [BYTE_W-1:0]    shift_q;
   logic                 full_q;
   logic                 rd_mode_q;
   logic                 mst_ack_q;
   logic [ADDR_W-1:0]    ptr_q;
   logic                 oe_q;
   logic                 wr_q;
   logic [BYTE_W-1:0]    wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         kind_q    <= RX_DEVADDR;
         bit_q     <= '0;
         shift_q   <= '0;
         full_q    <= 1'b0;
         rd_mode_q <= 1'b0;
         mst_ack_q <= 1'b0;
         ptr_q     <= '0;
         oe_q      <= 1'b0;
         wr_q      <= 1'b0;
         wdata_q   <= '0;
      end else if (pwr_fail) begin
         state_q <= ST_IDLE;
         full_q  <= 1'b0;
         ptr_q   <= '0;
         oe_q    <= 1'b0;
         wr_q    <= 1'b0;
      end else begin
         wr_q <= 1'b0;
         // the pointer steps the cycle after the write strobe
         if (wr_q) ptr_q <= ptr_q + 1'b1;

         if (ev_start) begin
            state_q <= ST_RX;
            kind_q  <= RX_DEVADDR;
            bit_q   <= '0;
            full_q  <= 1'b0;
            oe_q    <= 1'b0;
         end else if (ev_stop) begin
            state_q <= ST_IDLE;
            full_q  <= 1'b0;
            oe_q    <= 1'b0;
         end else begin
            case (state_q)
               ST_RX: begin
                  if (ev_rise) begin
                     shift_q <= {shift_q[BYTE_W-2:0], sda_f};
                     bit_q   <= bit_q + 1'b1;
                     if (bit_q == LAST_BIT) full_q <= 1'b1;
                  end else if (ev_fall && full_q) begin
                     full_q <= 1'b0;
                     if (kind_q == RX_DEVADDR) begin
                        if (shift_q[BYTE_W-1:1] == DEV_ADDR) begin
                           rd_mode_q <= shift_q[0];
                           oe_q      <= 1'b1;
                           state_q   <= ST_ACK_OUT;
                        end else begin
                           state_q <= ST_IDLE;
                        end
                     end else begin
                        oe_q    <= 1'b1;
                        state_q <= ST_ACK_OUT;
                     end
                  end
               end
               ST_ACK_OUT: begin
                  if (ev_fall) begin
                     oe_q <= 1'b0;
                     case (kind_q)
                        RX_DEVADDR: begin
                           if (rd_mode_q) begin
                              state_q <= ST_TX_LOAD;
                           end else begin
                              state_q <= ST_RX;
                              kind_q  <= RX_PTR;
                           end
                        end
                        RX_PTR: begin
                           ptr_q   <= shift_q[ADDR_W-1:0];
                           kind_q  <= RX_DATA;
                           state_q <= ST_RX;
                        end
                        default: begin
                           wr_q    <= 1'b1;
                           wdata_q <= shift_q;
                           state_q <= ST_RX;
                        end
                     endcase
                  end
               end
               ST_TX_LOAD: begin
                  shift_q <= reg_rdata;
                  oe_q    <= ~reg_rdata[BYTE_W-1];
                  bit_q   <= '0;
                  state_q <= ST_TX;
               end
               ST_TX: begin
                  if (ev_fall) begin
                     if (bit_q == LAST_BIT) begin
                        oe_q    <= 1'b0;
                        bit_q   <= '0;
                        state_q <= ST_ACK_IN;
                     end else begin
                        oe_q    <= ~shift_q[BYTE_W-2];
                        shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
                        bit_q   <= bit_q + 1'b1;
                     end
                  end
               end
               ST_ACK_IN: begin
                  if (ev_rise) begin
                     mst_ack_q <= ~sda_f;
                  end else if (ev_fall) begin
                     if (mst_ack_q) begin
                        ptr_q   <= ptr_q + 1'b1;
                        state_q <= ST_TX_LOAD;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe    = oe_q;
   assign reg_addr  = ptr_q;
   assign reg_wr_en = wr_q;
   assign reg_wdata = wdata_q;

   AST_PF_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> (reg_addr == '0)); // R7
   AST_PF_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> (!sda_oe && !reg_wr_en)); // R7
   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> !reg_wr_en); // R2
   AST_PTR_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && !pwr_fail) |=> (reg_addr == ADDR_W'($past(reg_addr) + 1'b1))); // R2
   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_fail && !$past(pwr_fail) && (sda_oe != $past(sda_oe))) |-> !scl_f); // R12

endmodule

// File: rtl/twi_regfile_slave.sv
module twi_regfile_slave
   import twi_rf_pkg::*;
#(
   parameter int         ADDR_W      = 6,
   parameter logic [6:0] DEV_ADDR    = 7'h68,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_fail,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_wr_en,
   output logic [7:0]        reg_wdata,
   input  logic [7:0]        reg_rdata
);

   logic [LINE_CNT-1:0] raw_lines;
   logic [LINE_CNT-1:0] filt_lines;
   logic ev_start, ev_stop, ev_rise, ev_fall;

   assign raw_lines = {sda_i, scl_i};

   for (genvar g = 0; g < LINE_CNT; g++) begin : g_line
      twi_line_filter #(
         .SYNC_STAGES(SYNC_STAGES),
         .FILT_LEN   (FILT_LEN)
      ) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .line_i(raw_lines[g]),
         .line_o(filt_lines[g])
      );
   end

   twi_bus_events u_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_f   (filt_lines[0]),
      .sda_f   (filt_lines[1]),
      .ev_start(ev_start),
      .ev_stop (ev_stop),
      .ev_rise (ev_rise),
      .ev_fall (ev_fall)
   );

   twi_slave_core #(
      .ADDR_W  (ADDR_W),
      .DEV_ADDR(DEV_ADDR)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_fail (pwr_fail),
      .ev_start (ev_start),
      .ev_stop  (ev_stop),
      .ev_rise  (ev_rise),
      .ev_fall  (ev_fall),
      .scl_f    (filt_lines[0]),
      .sda_f    (filt_lines[1]),
      .reg_rdata(reg_rdata),
      .sda_oe   (sda_oe),
      .reg_addr (reg_addr),
      .reg_wr_en(reg_wr_en),
      .reg_wdata(reg_wdata)
   );

endmodule

// File: tb/twi_regfile_slave_tb_top.sv
module twi_regfile_slave_tb_top;

   localparam int AW    = 6;
   localparam int DEPTH = 1 << AW;
   localparam int Q     = 15;
   localparam logic [7:0] DEV_W = 8'hD0;
   localparam logic [7:0] DEV_R = 8'hD1;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0, pwr_fail = 1'b0;
   logic m_scl = 1'b1, m_sda_low = 1'b0, scl_gl = 1'b0, sda_gl = 1'b0;
   logic glitch_on = 1'b0;
   logic sda_oe, reg_wr_en;
   logic [AW-1:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic sda_line, scl_in, sda_in;

   assign sda_line = !(m_sda_low || sda_oe);
   assign scl_in   = m_scl ^ scl_gl;
   assign sda_in   = sda_line ^ sda_gl;

   twi_regfile_slave dut_i (
      .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
      .scl_i(scl_in), .sda_i(sda_in), .sda_oe(sda_oe),
      .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   function automatic logic [7:0] init_byte(int i);
      return 8'((i * 29 + 7) ^ (i << 3));
   endfunction

   // storage model behind the register interface
   logic [7:0] mem [DEPTH];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= init_byte(i);
      end else if (reg_wr_en) begin
         mem[reg_addr] <= reg_wdata;
      end
   end
   assign reg_rdata = mem[reg_addr];

   // hold-time monitor on the pad level
   logic prev_oe = 1'b0;
   int   hold_viol = 0;
   always @(negedge clk) begin
      if (rst_n && !pwr_fail && (sda_oe !== prev_oe) && m_scl) hold_viol++;
      prev_oe = sda_oe;
   end

   int n_checks = 0, n_err = 0;
   logic [7:0]    exp_mem [DEPTH];
   logic [AW-1:0] exp_ptr = '0;
   logic [7:0]    pay [8];

   task automatic finish_sim();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog (all requirements): actual timeout, expected completion");
      finish_sim();
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      if (!m_scl) begin
         m_sda_low = 1'b0; tick(Q);
         m_scl = 1'b1;     tick(Q);
      end else begin
         m_sda_low = 1'b0; tick(Q);
      end
      m_sda_low = 1'b1; tick(Q);
      m_scl = 1'b0;     tick(Q);
   endtask

   task automatic bus_stop();
      m_sda_low = 1'b1; tick(Q);
      m_scl = 1'b1;     tick(Q);
      m_sda_low = 1'b0; tick(Q);
   endtask

   task automatic clk_bit(input logic b, output logic seen);
      m_sda_low = !b;
      if (glitch_on) begin
         tick(5); scl_gl = 1'b1; tick(2); scl_gl = 1'b0; tick(Q - 7);
      end else begin
         tick(Q);
      end
      m_scl = 1'b1;
      tick(Q);
      seen = sda_line;
      if (glitch_on) begin
         sda_gl = 1'b1; tick(2); sda_gl = 1'b0; tick(Q - 2);
      end else begin
         tick(Q);
      end
      m_scl = 1'b0;
      tick(Q);
   endtask

   task automatic wr_byte(input logic [7:0] v, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
      clk_bit(1'b1, s);
      ack = !s;
   endtask

   task automatic rd_byte(input bit give_ack, output logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         v[i] = s;
      end
      clk_bit(!give_ack, s);
   endtask

   task automatic do_write(input logic [AW-1:0] p, input int n, input string req);
      logic a;
      bus_start();
      wr_byte(DEV_W, a);
      check(a == 1'b1, "R1", "write address ack", a, 1);
      wr_byte(8'(p), a);
      check(a == 1'b1, "R3", "pointer byte ack", a, 1);
      exp_ptr = p;
      check(reg_addr == exp_ptr, "R2", "pointer load", reg_addr, exp_ptr);
      for (int k = 0; k < n; k++) begin
         wr_byte(pay[k], a);
         check(a == 1'b1, "R3", "data byte ack", a, 1);
         exp_mem[exp_ptr] = pay[k];
         check(mem[exp_ptr] == pay[k], req, "stored byte", mem[exp_ptr], pay[k]);
         exp_ptr = exp_ptr + 1'b1;
         check(reg_addr == exp_ptr, req, "pointer after write", reg_addr, exp_ptr);
      end
      bus_stop();
   endtask

   task automatic do_read(input bit set_ptr, input logic [AW-1:0] p, input int n,
                          input string req);
      logic a;
      logic [7:0] v;
      if (set_ptr) begin
         bus_start();
         wr_byte(DEV_W, a);
         check(a == 1'b1, "R1", "write address ack", a, 1);
         wr_byte(8'(p), a);
         check(a == 1'b1, "R3", "pointer byte ack", a, 1);
         exp_ptr = p;
      end
      bus_start();
      wr_byte(DEV_R, a);
      check(a == 1'b1, "R1", "read address ack", a, 1);
      for (int k = 0; k < n; k++) begin
         bit ga;
         ga = (k < n - 1);
         rd_byte(ga, v);
         check(v == exp_mem[exp_ptr], req, "read data", v, exp_mem[exp_ptr]);
         if (ga) exp_ptr = exp_ptr + 1'b1;
         check(reg_addr == exp_ptr, "R4", "pointer after read byte", reg_addr, exp_ptr);
      end
      check(sda_oe == 1'b0, "R5", "SDA released after master NACK", sda_oe, 0);
      bus_stop();
   endtask

   initial begin
      logic a;
      logic s;
      void'($urandom(32'h1A2B_3C4D));
      for (int i = 0; i < DEPTH; i++) exp_mem[i] = init_byte(i);
      tick(10);
      check(sda_oe == 1'b0, "R13", "reset sda_oe", sda_oe, 0);
      check(reg_wr_en == 1'b0, "R13", "reset reg_wr_en", reg_wr_en, 0);
      check(reg_addr == '0, "R13", "reset reg_addr", reg_addr, 0);
      rst_n = 1'b1;
      tick(5);

      // R2 R3: plain write burst
      pay[0] = 8'hA5; pay[1] = 8'h00; pay[2] = 8'hFF;
      do_write(6'd5, 3, "R2");

      // R4 R5: pointer-load read, NACK on the last byte
      do_read(1'b1, 6'd5, 3, "R4");

      // R6: current-pointer read continues from 7
      do_read(1'b0, '0, 2, "R6");

      // R10: wrap while writing and while reading
      pay[0] = 8'h62; pay[1] = 8'h63; pay[2] = 8'h64;
      do_write(6'd62, 3, "R10");
      do_read(1'b1, 6'd63, 3, "R10");

      // R1: foreign address ignored, nothing written
      bus_start();
      wr_byte(8'hA0, a);
      check(a == 1'b0, "R1", "foreign address not acked", a, 0);
      wr_byte(8'h10, a);
      check(a == 1'b0, "R1", "byte after foreign address not acked", a, 0);
      wr_byte(8'h77, a);
      check(mem[16] == exp_mem[16], "R1", "no write after foreign address", mem[16], exp_mem[16]);
      check(reg_addr == exp_ptr, "R1", "pointer untouched", reg_addr, exp_ptr);
      bus_start();
      wr_byte(8'hD3, a);
      check(a == 1'b0, "R1", "near-miss read address not acked", a, 0);
      bus_stop();

      // R8: bytes clocked after STOP without START
      wr_byte(DEV_W, a);
      check(a == 1'b0, "R8", "no ack without START", a, 0);
      wr_byte(8'h22, a);
      check(reg_addr == exp_ptr, "R8", "pointer untouched without START", reg_addr, exp_ptr);
      bus_stop();

      // R11: repeated START mid-write
      bus_start();
      wr_byte(DEV_W, a);
      wr_byte(8'd20, a);
      wr_byte(8'h11, a);
      exp_mem[20] = 8'h11;
      bus_start();
      wr_byte(DEV_W, a);
      check(a == 1'b1, "R11", "address ack after repeated START", a, 1);
      wr_byte(8'd30, a);
      wr_byte(8'h22, a);
      exp_mem[30] = 8'h22;
      exp_ptr = 6'd31;
      bus_stop();
      check(mem[20] == 8'h11, "R11", "byte before repeated START", mem[20], 8'h11);
      check(mem[30] == 8'h22, "R11", "byte after repeated START", mem[30], 8'h22);

      // R7: power failure in the middle of a byte
      bus_start();
      wr_byte(DEV_W, a);
      wr_byte(8'd40, a);
      wr_byte(8'h5A, a);
      exp_mem[40] = 8'h5A;
      clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
      pwr_fail = 1'b1;
      tick(3);
      exp_ptr = '0;
      check(reg_addr == '0, "R7", "pointer cleared", reg_addr, 0);
      check(sda_oe == 1'b0, "R7", "SDA released", sda_oe, 0);
      for (int i = 0; i < 5; i++) clk_bit(1'b0, s);
      clk_bit(1'b1, s);
      check(s == 1'b1, "R7", "no ack of aborted byte", s, 1);
      bus_start();
      wr_byte(DEV_W, a);
      check(a == 1'b0, "R7", "address ignored during power fail", a, 0);
      wr_byte(8'h09, a);
      check(a == 1'b0, "R7", "pointer byte ignored during power fail", a, 0);
      bus_stop();
      check(mem[41] == exp_mem[41], "R7", "aborted byte not stored", mem[41], exp_mem[41]);
      check(reg_addr == '0, "R7", "pointer held at zero", reg_addr, 0);
      pwr_fail = 1'b0;
      tick(5);
      do_read(1'b0, '0, 1, "R7");

      // R9: short pulses on both lines during write and read
      glitch_on = 1'b1;
      pay[0] = 8'h3C; pay[1] = 8'hC3;
      do_write(6'd10, 2, "R9");
      do_read(1'b1, 6'd10, 2, "R9");
      glitch_on = 1'b0;

      // seeded random mix
      for (int t = 0; t < 24; t++) begin
         int kind;
         int n;
         logic [AW-1:0] p;
         kind = $urandom_range(0, 2);
         n = $urandom_range(1, 4);
         if ($urandom_range(0, 2) == 0) p = AW'(DEPTH - 1 - $urandom_range(0, 2));
         else                           p = AW'($urandom_range(0, DEPTH - 1));
         for (int k = 0; k < n; k++) pay[k] = 8'($urandom);
         case (kind)
            0:       do_write(p, n, "R2");
            1:       do_read(1'b1, p, n, "R4");
            default: do_read(1'b0, '0, n, "R6");
         endcase
      end

      check(hold_viol == 0, "R12", "sda_oe changed while SCL high", hold_viol, 0);
      for (int i = 0; i < DEPTH; i++)
         check(mem[i] == exp_mem[i], "R2", "final storage contents", mem[i], exp_mem[i]);
      finish_sim();
   end

endmodule